// File: doc/BRIEF.md
# Serial Flash Continuous Read Engine

This block is the device-side read path of a serial flash. It sits behind an SPI-compatible slave port that works in clock modes 0 and 3. A host pulls chip select low and shifts in one command byte and a 24-bit address. The host then clocks a fixed number of filler bytes. From then on the block streams main-array bytes on its serial output, most significant bit first, for as long as the host keeps clocking and holds chip select low. An internal address counter walks the array. When it passes the end of a page it goes on into the next page, and after the last page it returns to page 0. No extra clocks are needed at either boundary.

Two read commands are decoded, and they differ only in their filler length. The array can be seen as 264-byte pages or as 256-byte binary pages; a static configuration pin chooses between them, and the choice changes how the address is split into page and offset. All byte-level logic runs on the system clock. The serial clock, chip select and data input are synchronized and edge-detected, so the system clock must run several times faster than the serial clock. The array itself is a synchronous memory with a byte-wide load port that the rest of the device uses to fill it.

Top module: `cread_engine`

## Requirements
- R1: After reset, and whenever chip select is high, the output enable `so_oe` is low.
- R2: Command byte E8h is followed by 3 address bytes and 4 filler bytes. The first data bit is driven after the falling serial-clock edge that follows the last filler bit, and `so_oe` stays low before that point.
- R3: Command byte 0Bh is followed by 3 address bytes and exactly 1 filler byte, and then data starts in the same way as for E8h.
- R4: With `bin_page` low, the 24-bit address (sent MSB first) carries the page number in bits 18..9 and the byte offset in bits 8..0, and the first byte returned is the one stored at that page and offset.
- R5: With `bin_page` high, the page number is in address bits 17..8 and the byte offset in bits 7..0.
- R6: After the last byte of a page (offset 263 with `bin_page` low, offset 255 with it high), the next byte returned is byte 0 of the following page, with no extra serial clocks.
- R7: After the last byte of the last page, the stream continues at byte 0 of page 0 with no gap.
- R8: A rising edge on chip select ends a read at any bit and drives `so_oe` low within four system clocks. The next transaction then decodes normally from its command byte.
- R9: Any other command byte makes the block ignore the data input and keep `so_oe` low until chip select rises.
- R10: With `bin_page` low, a starting offset from 264 to 511 is treated as byte 0 of the next page, and the last page goes on to page 0.
- R11: A read leaves the array contents unchanged, so a repeated read of the same range returns the same bytes.
- R12: Data bits change only after a falling serial-clock edge and are held across the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_page | input | 1 | Page layout select: 1 = 256-byte pages, 0 = 264-byte pages; change only while chip select is high |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on rising serial-clock edges |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable of the serial data pad; low means high impedance |
| ld_en | input | 1 | Array load strobe |
| ld_page | input | PAGE_BITS | Page written by the load port |
| ld_off | input | 9 | Byte offset written by the load port |
| ld_byte | input | 8 | Byte written by the load port |

## Verification
The bench fills the array with a byte pattern that differs for every page and offset. Against that pattern, a wrong filler count shows up as a stream shifted by whole bytes, and a wrong address split shows up as data from the wrong page. Reads are started just before a page end in both layouts and just before the end of the array. A design that stalled, repeated a byte or wrapped to the start of the same page would then return a byte out of sequence. Offsets beyond the 264-byte page, an unknown command, and chip select raised in the middle of a byte are also driven. A design that indexed past the page, drove the pad for a bad command or kept driving after deselect would show the wrong byte or a high enable. Mode 3 transactions start with a falling edge before the first bit, which catches a design that counts that edge as data.

// File: rtl/cread_pkg.sv
package cread_pkg;
  // command bytes recognised by the read engine
  localparam logic [7:0] OPC_LEGACY = 8'hE8;
  localparam logic [7:0] OPC_FAST   = 8'h0B;

  // filler bytes that follow the address for each command
  localparam logic [2:0] DUM_LEGACY = 3'd4;
  localparam logic [2:0] DUM_FAST   = 3'd1;

  localparam int unsigned ADR_BYTES = 3;
  localparam int unsigned PFIELD_W  = 10;
  localparam int unsigned OFF_W     = 9;
  localparam int unsigned ADR_W     = 19;
  localparam int unsigned STD_PAGE  = 264;

  localparam logic [OFF_W-1:0] STD_LIM  = 9'd264;
  localparam logic [OFF_W-1:0] BIN_LIM  = 9'd256;
  localparam logic [OFF_W-1:0] STD_LAST = 9'd263;
  localparam logic [OFF_W-1:0] BIN_LAST = 9'd255;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DUM,
    ST_DATA,
    ST_IGN
  } rd_state_e;
endpackage

// File: rtl/cread_sync.sv
module cread_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] d_sync
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[gi]}};
        else        chain <= {chain[STAGES-2:0], d_async[gi]};
      end
      assign d_sync[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cread_addr.sv
module cread_addr
  import cread_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 3
) (
  input  logic                 bin_page,
  input  logic [ADR_W-1:0]     cmd_adr,
  input  logic [PAGE_BITS-1:0] cur_page,
  input  logic [OFF_W-1:0]     cur_off,
  output logic [PAGE_BITS-1:0] start_page,
  output logic [OFF_W-1:0]     start_off,
  output logic [PAGE_BITS-1:0] step_page,
  output logic [OFF_W-1:0]     step_off
);
  logic [PFIELD_W-1:0] raw_pf;
  logic [OFF_W-1:0]    raw_off;
  logic [OFF_W-1:0]    last_off;

  // split of the command address into page field and byte offset
  always_comb begin
    if (bin_page) begin
      raw_pf  = cmd_adr[17:8];
      raw_off = {1'b0, cmd_adr[7:0]};
    end else begin
      raw_pf  = cmd_adr[18:9];
      raw_off = cmd_adr[8:0];
    end
    start_page = PAGE_BITS'(raw_pf);
    start_off  = raw_off;
    // offsets beyond a 264-byte page fold to the start of the next page
    if (!bin_page && (raw_off >= STD_LIM)) begin
      start_page = PAGE_BITS'(raw_pf) + PAGE_BITS'(1);
      start_off  = '0;
    end
  end

  // sequential advance with page crossover and array wrap
  always_comb begin
    last_off = bin_page ? BIN_LAST : STD_LAST;
    if (cur_off >= last_off) begin
      step_off  = '0;
      step_page = cur_page + PAGE_BITS'(1);
    end else begin
      step_off  = cur_off + OFF_W'(1);
      step_page = cur_page;
    end
  end
endmodule

// File: rtl/cread_array.sv
module cread_array
  import cread_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 ld_en,
  input  logic [PAGE_BITS-1:0] ld_page,
  input  logic [OFF_W-1:0]     ld_off,
  input  logic [7:0]           ld_byte,
  input  logic                 rd_en,
  input  logic [PAGE_BITS-1:0] rd_page,
  input  logic [OFF_W-1:0]     rd_off,
  output logic [7:0]           rd_byte
);
  localparam int unsigned PAGES = 1 << PAGE_BITS;
  localparam int unsigned DEPTH = PAGES * STD_PAGE;
  localparam int unsigned AW    = $clog2(DEPTH) + 1;

  logic [7:0] mem [DEPTH];

  function automatic logic [AW-1:0] lin(input logic [PAGE_BITS-1:0] pg,
                                        input logic [OFF_W-1:0] off);
    return AW'(pg) * AW'(STD_PAGE) + AW'(off);
  endfunction

  always_ff @(posedge clk) begin
    if (ld_en) mem[lin(ld_page, ld_off)] <= ld_byte;
    if (rd_en) rd_byte <= mem[lin(rd_page, rd_off)];
  end
endmodule

// File: rtl/cread_engine.sv
module cread_engine
  import cread_pkg::*;
#(
  parameter int unsigned PAGE_BITS   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bin_page,
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 si,
  output logic                 so,
  output logic                 so_oe,
  input  logic                 ld_en,
  input  logic [PAGE_BITS-1:0] ld_page,
  input  logic [OFF_W-1:0]     ld_off,
  input  logic [7:0]           ld_byte
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  // pin synchronisation and serial clock edge detection
  logic cs_s, sck_s, si_s, sck_q, rise, fall;
  cread_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_i),
    .d_async ({cs_n, sck, si}),
    .d_sync  ({cs_s, sck_s, si_s})
  );
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end
  assign rise = sck_s & ~sck_q;
  assign fall = ~sck_s & sck_q;

  // state
  rd_state_e            st_q, st_n;
  logic [2:0]           bit_q, bit_n;
  logic [2:0]           byt_q, byt_n;
  logic [2:0]           dum_q, dum_n;
  logic [7:0]           opc_q, opc_n;
  logic [ADR_W-1:0]     adr_q, adr_n;
  logic [PAGE_BITS-1:0] pg_q, pg_n;
  logic [OFF_W-1:0]     off_q, off_n;
  logic [6:0]           sh_q, sh_n;
  logic [2:0]           obit_q, obit_n;
  logic                 so_q, so_n;
  logic                 oe_q, oe_n;
  logic                 rd_en;
  logic [7:0]           nxt_byte;

  logic [PAGE_BITS-1:0] start_page, step_page;
  logic [OFF_W-1:0]     start_off, step_off;

  cread_addr #(.PAGE_BITS(PAGE_BITS)) u_addr (
    .bin_page   (bin_page),
    .cmd_adr    (adr_q),
    .cur_page   (pg_q),
    .cur_off    (off_q),
    .start_page (start_page),
    .start_off  (start_off),
    .step_page  (step_page),
    .step_off   (step_off)
  );

  // the read port addresses the byte that becomes the prefetch
  cread_array #(.PAGE_BITS(PAGE_BITS)) u_array (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_page (ld_page),
    .ld_off  (ld_off),
    .ld_byte (ld_byte),
    .rd_en   (rd_en),
    .rd_page (pg_n),
    .rd_off  (off_n),
    .rd_byte (nxt_byte)
  );

  // next-state logic
  always_comb begin
    st_n   = st_q;
    bit_n  = bit_q;
    byt_n  = byt_q;
    dum_n  = dum_q;
    opc_n  = opc_q;
    adr_n  = adr_q;
    pg_n   = pg_q;
    off_n  = off_q;
    sh_n   = sh_q;
    obit_n = obit_q;
    so_n   = so_q;
    oe_n   = oe_q;
    rd_en  = 1'b0;
    if (cs_s) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_n  = ST_OPC;
          bit_n = '0;
          byt_n = '0;
        end
        ST_OPC: if (rise) begin
          opc_n = {opc_q[6:0], si_s};
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            byt_n = '0;
            if (opc_n == OPC_LEGACY) begin
              st_n  = ST_ADR;
              dum_n = DUM_LEGACY;
            end else if (opc_n == OPC_FAST) begin
              st_n  = ST_ADR;
              dum_n = DUM_FAST;
            end else begin
              st_n  = ST_IGN;
            end
          end
        end
        ST_ADR: if (rise) begin
          adr_n = {adr_q[ADR_W-2:0], si_s};
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            byt_n = byt_q + 3'd1;
            if (byt_q == 3'(ADR_BYTES - 1)) begin
              st_n  = ST_DUM;
              byt_n = '0;
            end
          end
        end
        ST_DUM: if (rise) begin
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            byt_n = byt_q + 3'd1;
            if (byt_q == dum_q - 3'd1) begin
              st_n   = ST_DATA;
              pg_n   = start_page;
              off_n  = start_off;
              obit_n = '0;
              rd_en  = 1'b1;
            end
          end
        end
        ST_DATA: if (fall) begin
          oe_n = 1'b1;
          if (obit_q == 3'd0) begin
            so_n   = nxt_byte[7];
            sh_n   = nxt_byte[6:0];
            obit_n = 3'd7;
            pg_n   = step_page;
            off_n  = step_off;
            rd_en  = 1'b1;
          end else begin
            so_n   = sh_q[6];
            sh_n   = {sh_q[5:0], 1'b0};
            obit_n = obit_q - 3'd1;
          end
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      byt_q  <= '0;
      dum_q  <= '0;
      opc_q  <= '0;
      adr_q  <= '0;
      pg_q   <= '0;
      off_q  <= '0;
      sh_q   <= '0;
      obit_q <= '0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      bit_q  <= bit_n;
      byt_q  <= byt_n;
      dum_q  <= dum_n;
      opc_q  <= opc_n;
      adr_q  <= adr_n;
      pg_q   <= pg_n;
      off_q  <= off_n;
      sh_q   <= sh_n;
      obit_q <= obit_n;
      so_q   <= so_n;
      oe_q   <= oe_n;
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;

  // R1 R8
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    cs_s |=> !oe_q);

  // R9
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_IGN) |-> !oe_q);

  // R12
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !fall |=> $stable(so_q));

  // R6 R10
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_DATA) |-> (off_q < (bin_page ? BIN_LIM : STD_LIM)));

  // R2 R3
  dum_len_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_DUM) |-> (dum_q == DUM_LEGACY || dum_q == DUM_FAST));
endmodule

// File: tb/sim_cread_engine.sv
`timescale 1ns/1ps
module sim_cread_engine;
  localparam int PB = 3;
  localparam int NPG = 1 << PB;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bin_page = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic ld_en = 1'b0;
  logic [PB-1:0] ld_page = '0;
  logic [8:0] ld_off = '0;
  logic [7:0] ld_byte = '0;
  logic so, so_oe;

  int total = 0;
  int bad = 0;
  bit hold_err = 1'b0;

  always #2 clk = ~clk;

  cread_engine #(.PAGE_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .bin_page(bin_page), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .ld_en(ld_en), .ld_page(ld_page), .ld_off(ld_off),
    .ld_byte(ld_byte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pat(input int p, input int o);
    return (p * 71 + o * 3 + (o / 256) * 100 + 5) & 255;
  endfunction

  task automatic bit_io(input logic b, output logic s_so, output logic s_oe);
    logic mid;
    sck = 1'b0;
    si = b;
    waitn(H);
    s_so = so;
    s_oe = so_oe;
    sck = 1'b1;
    waitn(H / 2);
    mid = so;
    if (s_oe && (mid !== s_so)) hold_err = 1'b1;
    waitn(H / 2);
  endtask

  task automatic xfer(input logic [7:0] ob, output logic [7:0] ib, inout bit oe_seen);
    logic s, e;
    for (int i = 7; i >= 0; i--) begin
      bit_io(ob[i], s, e);
      ib[i] = s;
      if (e) oe_seen = 1'b1;
    end
  endtask

  task automatic begin_txn(input bit m3);
    sck = m3;
    waitn(4);
    cs_n = 1'b0;
    waitn(4);
  endtask

  task automatic end_txn(input bit m3);
    if (!m3) begin
      sck = 1'b0;
      waitn(H);
    end
    cs_n = 1'b1;
    waitn(6);
    check(so_oe == 1'b0, "R8 deselect", so_oe, 0);
  endtask

  task automatic send_head(input logic [7:0] opc, input bit p256, input int page,
                           input int off, inout bit oe_seen);
    logic [23:0] adr;
    logic [7:0] dummy;
    adr = p256 ? 24'((page << 8) | (off & 255)) : 24'((page << 9) | (off & 511));
    xfer(opc, dummy, oe_seen);
    xfer(adr[23:16], dummy, oe_seen);
    xfer(adr[15:8], dummy, oe_seen);
    xfer(adr[7:0], dummy, oe_seen);
    for (int d = 0; d < ((opc == 8'hE8) ? 4 : 1); d++) xfer(8'hFF, dummy, oe_seen);
  endtask

  task automatic do_read(input logic [7:0] opc, input bit p256, input int page,
                         input int off, input int nb, input bit m3, input string tag);
    bit oe_seen;
    logic [7:0] got;
    int ep, eo, last;
    bin_page = p256;
    hold_err = 1'b0;
    oe_seen = 1'b0;
    begin_txn(m3);
    send_head(opc, p256, page, off, oe_seen);
    check(!oe_seen, (opc == 8'hE8) ? "R2 quiet before data" : "R3 quiet before data",
          oe_seen, 0);
    ep = page % NPG;
    eo = p256 ? (off & 255) : off;
    if (!p256 && eo >= 264) begin
      eo = 0;
      ep = (ep + 1) % NPG;
    end
    last = p256 ? 255 : 263;
    for (int k = 0; k < nb; k++) begin
      xfer(8'h00, got, oe_seen);
      check(got == 8'(pat(ep, eo)), tag, got, pat(ep, eo));
      if (eo == last) begin
        eo = 0;
        ep = (ep + 1) % NPG;
      end else begin
        eo++;
      end
    end
    check(!hold_err, "R12 hold over rise", hold_err, 0);
    end_txn(m3);
  endtask

  task automatic t_reset;
    check(so_oe == 1'b0, "R1 reset", so_oe, 0);
  endtask

  task automatic t_unknown;
    bit oe_seen;
    logic [7:0] got;
    oe_seen = 1'b0;
    begin_txn(1'b0);
    xfer(8'h03, got, oe_seen);
    for (int k = 0; k < 6; k++) xfer(8'hA5, got, oe_seen);
    check(!oe_seen, "R9 unknown opcode", oe_seen, 0);
    end_txn(1'b0);
    do_read(8'h0B, 1'b0, 3, 17, 3, 1'b0, "R9 recover");
  endtask

  task automatic t_abort;
    bit oe_seen;
    logic [7:0] got;
    logic s, e;
    oe_seen = 1'b0;
    bin_page = 1'b0;
    begin_txn(1'b0);
    send_head(8'hE8, 1'b0, 2, 40, oe_seen);
    xfer(8'h00, got, oe_seen);
    for (int i = 0; i < 3; i++) bit_io(1'b0, s, e);
    check(so_oe == 1'b1, "R8 driving before abort", so_oe, 1);
    cs_n = 1'b1;
    waitn(4);
    check(so_oe == 1'b0, "R8 abort", so_oe, 0);
    sck = 1'b0;
    waitn(4);
    do_read(8'hE8, 1'b0, 2, 40, 2, 1'b0, "R8 fresh command");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitn(5);
    rst_n = 1'b1;
    waitn(5);
    t_reset();
    for (int p = 0; p < NPG; p++) begin
      for (int o = 0; o < 264; o++) begin
        ld_en = 1'b1;
        ld_page = PB'(p);
        ld_off = 9'(o);
        ld_byte = 8'(pat(p, o));
        waitn(1);
      end
    end
    ld_en = 1'b0;
    waitn(4);
    do_read(8'hE8, 1'b0, 2, 5, 4, 1'b0, "R2 R4 legacy std");
    do_read(8'h0B, 1'b1, 3, 10, 4, 1'b0, "R3 R5 fast bin");
    do_read(8'h0B, 1'b0, 1, 261, 5, 1'b0, "R6 std crossover");
    do_read(8'hE8, 1'b1, 4, 254, 4, 1'b1, "R6 bin crossover");
    do_read(8'h0B, 1'b0, 7, 262, 4, 1'b1, "R7 std array wrap");
    do_read(8'hE8, 1'b1, 7, 255, 3, 1'b1, "R7 bin array wrap");
    do_read(8'h0B, 1'b0, 5, 300, 3, 1'b0, "R10 oversize offset");
    do_read(8'hE8, 1'b0, 7, 400, 2, 1'b0, "R10 oversize last page");
    do_read(8'hE8, 1'b0, 2, 5, 4, 1'b0, "R11 repeat read");
    t_unknown();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule